// File: doc/BRIEF.md
# Tagged Translation Cache with Selective Invalidation

This block is a small, fully associative cache of address translations for a 4KB page size. Each slot stores a virtual page number, a physical page number, a set of attribute bits (memory type, cache policy and access permission), an address-space tag and a virtual-machine tag. Each slot also carries two flags: one marks a global mapping and one marks a 64KB contiguous mapping. The lookup port compares the presented virtual address and both tags against every slot. The answer is combinational, so the requester sees it in the cycle the lookup is presented.

When a lookup misses, the block raises a walk request to an external table walker. The walker returns its result on the fill port. A result without a fault is written into the first free slot, or into the slot named by a round-robin pointer when every slot is in use. A separate command port removes stale translations in one of five scopes: everything, by machine tag, by address-space tag, by page together with address-space tag, or by page under any address-space tag.

Top module: `tagged_tlb`

## Requirements
- R1: After reset every slot is empty, and any lookup reports lk_hit low.
- R2: A lookup hits when a valid slot has the same page number (lk_va[31:12]), the same VMID and the same ASID. lk_hit then rises in the same cycle, lk_pa is {stored physical page, lk_va[11:0]} and lk_attr is the stored attribute value. walk_req stays low on a hit.
- R3: A lookup that matches no valid slot drives lk_hit low and walk_req high. A mismatch in ASID alone, or in VMID alone, is a miss.
- R4: A fill with fill_fault low writes one slot, and that slot can be looked up from the next cycle. A fill with fill_fault high leaves every slot unchanged.
- R5: A slot filled with fill_global high matches any lookup ASID. The VMID must still match.
- R6: A slot filled with fill_contig high ignores page bits [15:12] when it compares, so it covers a 64KB region. On a hit through such a slot, lk_pa[15:12] are taken from lk_va[15:12].
- R7: inv_op code 0 removes every slot.
- R8: inv_op code 1 removes every slot whose VMID equals inv_vmid. All other slots are kept.
- R9: inv_op code 2 removes the non-global slots whose ASID equals inv_asid. Global slots survive.
- R10: inv_op code 3 removes slots that match inv_vpn and also match inv_asid or are global. A contiguous slot matches inv_vpn when its 64KB region contains that page.
- R11: inv_op code 4 removes slots that match inv_vpn whatever their ASID. A contiguous slot matches in the same region-based way as in R10.
- R12: While inv_valid is high, a lookup is reported as a miss with walk_req high. inv_op codes 5 to 7 remove nothing.
- R13: A fill goes to the lowest-numbered empty slot. When every slot is valid, it goes to the slot named by a round-robin pointer. The pointer starts at 0 and advances by one only when a fill uses it.
- R14: When an invalidation and a fill occur in the same cycle, the invalidation acts on the previous contents and the new translation is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space tag |
| lk_vmid | input | 8 | Lookup machine tag |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | 6 | Attributes of the hit slot |
| walk_req | output | 1 | Miss; table walk requested |
| fill_valid | input | 1 | Walk result present |
| fill_fault | input | 1 | Walk ended in a fault |
| fill_vpn | input | 20 | Virtual page of the result |
| fill_ppn | input | 20 | Physical page of the result |
| fill_attr | input | 6 | Attributes of the result |
| fill_asid | input | 8 | Address-space tag of the result |
| fill_vmid | input | 8 | Machine tag of the result |
| fill_global | input | 1 | Result matches any ASID |
| fill_contig | input | 1 | Result covers an aligned 64KB region |
| inv_valid | input | 1 | Invalidation command present |
| inv_op | input | 3 | Scope: 0 all, 1 VMID, 2 ASID, 3 page+ASID, 4 page any ASID |
| inv_vpn | input | 20 | Page operand |
| inv_asid | input | 8 | ASID operand |
| inv_vmid | input | 8 | VMID operand |

## Verification
Two pairs of functions can fall in the same cycle. An invalidation can coincide with a lookup, and an invalidation can coincide with a fill. The bench provokes the first pair by presenting a lookup that would hit together with an invalidation. It expects a miss with a walk request in that cycle, and then a hit again if the scope removed nothing. The bench provokes the second pair by issuing invalidate-all in the same cycle as a fill. It judges the result by looking up the new translation afterwards and expecting it to be present.

// File: rtl/tlbt_pkg.sv
package tlbt_pkg;
  // invalidation scope codes
  localparam logic [2:0] OP_ALL     = 3'd0;
  localparam logic [2:0] OP_VMID    = 3'd1;
  localparam logic [2:0] OP_ASID    = 3'd2;
  localparam logic [2:0] OP_VA_ASID = 3'd3;
  localparam logic [2:0] OP_VA_ANY  = 3'd4;
  // a contiguous slot spans 2**CONTIG_LOG2 pages
  localparam int CONTIG_LOG2 = 4;
endpackage

// File: rtl/tlbt_entry.sv
module tlbt_entry
  import tlbt_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int VMID_W = 8,
  parameter int ATTR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VMID_W-1:0] wr_vmid,
  input  logic              wr_global,
  input  logic              wr_contig,
  input  logic              inv_en,
  input  logic [2:0]        inv_op,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VMID_W-1:0] inv_vmid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  output logic              valid,
  output logic              hit,
  output logic              kill,
  output logic [PPN_W-1:0]  out_ppn,
  output logic [ATTR_W-1:0] out_attr
);
  localparam logic [VPN_W-1:0] LOW_MASK = VPN_W'((1 << CONTIG_LOG2) - 1);

  logic [VPN_W-1:0]  vpn_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [ATTR_W-1:0] attr_q;
  logic [ASID_W-1:0] asid_q;
  logic [VMID_W-1:0] vmid_q;
  logic              glob_q, contig_q, valid_q;

  // page compare; a contiguous slot drops the low page bits
  function automatic logic page_eq(input logic [VPN_W-1:0] stored,
                                   input logic [VPN_W-1:0] probe,
                                   input logic             contig);
    logic [VPN_W-1:0] mask;
    mask = contig ? ~LOW_MASK : '1;
    return ((stored ^ probe) & mask) == '0;
  endfunction

  logic inv_sel;
  always_comb begin
    unique case (inv_op)
      OP_ALL:     inv_sel = 1'b1;
      OP_VMID:    inv_sel = (vmid_q == inv_vmid);
      OP_ASID:    inv_sel = (asid_q == inv_asid) && !glob_q;
      OP_VA_ASID: inv_sel = page_eq(vpn_q, inv_vpn, contig_q) &&
                            ((asid_q == inv_asid) || glob_q);
      OP_VA_ANY:  inv_sel = page_eq(vpn_q, inv_vpn, contig_q);
      default:    inv_sel = 1'b0;
    endcase
  end

  assign kill  = inv_en && valid_q && inv_sel;
  assign valid = valid_q;
  assign hit   = valid_q && page_eq(vpn_q, lk_vpn, contig_q) &&
                 (vmid_q == lk_vmid) && (glob_q || (asid_q == lk_asid));
  assign out_ppn  = contig_q ? ((ppn_q & ~LOW_MASK) | (lk_vpn & LOW_MASK)) : ppn_q;
  assign out_attr = attr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      vpn_q    <= '0;
      ppn_q    <= '0;
      attr_q   <= '0;
      asid_q   <= '0;
      vmid_q   <= '0;
      glob_q   <= 1'b0;
      contig_q <= 1'b0;
    end else if (wr_en) begin
      valid_q  <= 1'b1;
      vpn_q    <= wr_vpn;
      ppn_q    <= wr_ppn;
      attr_q   <= wr_attr;
      asid_q   <= wr_asid;
      vmid_q   <= wr_vmid;
      glob_q   <= wr_global;
      contig_q <= wr_contig;
    end else if (kill) begin
      valid_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/tlbt_victim.sv
module tlbt_victim #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid_vec,
  input  logic          fill_en,
  output logic [IW-1:0] victim
);
  logic [IW-1:0] rr_q, first_free;
  logic          full;

  assign full = &valid_vec;

  always_comb begin
    first_free = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid_vec[i]) first_free = IW'(i);
  end

  assign victim = full ? rr_q : first_free;

  always_ff @(posedge clk) begin
    if (!rst_n)
      rr_q <= '0;
    else if (fill_en && full)
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
  import tlbt_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ASID_W    = 8,
  parameter int VMID_W    = 8,
  parameter int ATTR_W    = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lk_valid,
  input  logic [VA_W-1:0]           lk_va,
  input  logic [ASID_W-1:0]         lk_asid,
  input  logic [VMID_W-1:0]         lk_vmid,
  output logic                      lk_hit,
  output logic [PA_W-1:0]           lk_pa,
  output logic [ATTR_W-1:0]         lk_attr,
  output logic                      walk_req,
  input  logic                      fill_valid,
  input  logic                      fill_fault,
  input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
  input  logic [PA_W-PAGE_BITS-1:0] fill_ppn,
  input  logic [ATTR_W-1:0]         fill_attr,
  input  logic [ASID_W-1:0]         fill_asid,
  input  logic [VMID_W-1:0]         fill_vmid,
  input  logic                      fill_global,
  input  logic                      fill_contig,
  input  logic                      inv_valid,
  input  logic [2:0]                inv_op,
  input  logic [VA_W-PAGE_BITS-1:0] inv_vpn,
  input  logic [ASID_W-1:0]         inv_asid,
  input  logic [VMID_W-1:0]         inv_vmid
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  // named internal events, observed by the bound checker
  logic                              fill_en;
  logic [IDX_W-1:0]                  victim;
  logic [N_ENTRIES-1:0]              valid_vec, hit_vec, kill_vec;
  logic [N_ENTRIES-1:0][PPN_W-1:0]   ppn_arr;
  logic [N_ENTRIES-1:0][ATTR_W-1:0]  attr_arr;
  logic [VPN_W-1:0]                  lk_vpn;

  assign fill_en = fill_valid && !fill_fault;
  assign lk_vpn  = lk_va[VA_W-1:PAGE_BITS];

  tlbt_victim #(.N(N_ENTRIES), .IW(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec),
    .fill_en(fill_en), .victim(victim)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    tlbt_entry #(
      .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W),
      .VMID_W(VMID_W), .ATTR_W(ATTR_W)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fill_en && (victim == IDX_W'(g))),
      .wr_vpn(fill_vpn), .wr_ppn(fill_ppn), .wr_attr(fill_attr),
      .wr_asid(fill_asid), .wr_vmid(fill_vmid),
      .wr_global(fill_global), .wr_contig(fill_contig),
      .inv_en(inv_valid), .inv_op(inv_op), .inv_vpn(inv_vpn),
      .inv_asid(inv_asid), .inv_vmid(inv_vmid),
      .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_vmid(lk_vmid),
      .valid(valid_vec[g]), .hit(hit_vec[g]), .kill(kill_vec[g]),
      .out_ppn(ppn_arr[g]), .out_attr(attr_arr[g])
    );
  end

  // lowest-numbered hitting slot wins
  logic [PPN_W-1:0]  sel_ppn;
  logic [ATTR_W-1:0] sel_attr;
  always_comb begin
    sel_ppn  = '0;
    sel_attr = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) begin
        sel_ppn  = ppn_arr[i];
        sel_attr = attr_arr[i];
      end
  end

  assign lk_hit   = lk_valid && !inv_valid && (|hit_vec);
  assign walk_req = lk_valid && !lk_hit;
  assign lk_pa    = {sel_ppn, lk_va[PAGE_BITS-1:0]};
  assign lk_attr  = sel_attr;
endmodule

// File: rtl/tlbt_checker.sv
module tlbt_checker #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic          lk_hit,
  input logic          walk_req,
  input logic          inv_valid,
  input logic [2:0]    inv_op,
  input logic          fill_valid,
  input logic          fill_fault,
  input logic          fill_en,
  input logic [N-1:0]  valid_vec,
  input logic [N-1:0]  kill_vec,
  input logic [IW-1:0] victim
);
  AST_INV_FORCES_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !lk_hit); // R12
  AST_MISS_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit) |-> walk_req); // R3
  AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !walk_req); // R2
  AST_FAULT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_fault && !inv_valid) |=> (valid_vec == $past(valid_vec))); // R4
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_vec[$past(victim)]); // R4
  AST_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_op == 3'd0 && !fill_en) |=> (valid_vec == '0)); // R7
  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(&valid_vec)) |-> !valid_vec[victim]); // R13
  AST_NO_STRAY_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv_valid || inv_op > 3'd4) |-> (kill_vec == '0)); // R12
endmodule

bind tagged_tlb tlbt_checker #(.N(N_ENTRIES), .IW(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .walk_req(walk_req), .inv_valid(inv_valid), .inv_op(inv_op),
  .fill_valid(fill_valid), .fill_fault(fill_fault), .fill_en(fill_en),
  .valid_vec(valid_vec), .kill_vec(kill_vec), .victim(victim)
);

// File: tb/sim_tagged_tlb.sv
`timescale 1ns/1ps
module sim_tagged_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0, lk_vmid = '0;
  logic        lk_hit, walk_req;
  logic [31:0] lk_pa;
  logic [5:0]  lk_attr;
  logic        fill_valid = 1'b0, fill_fault = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [5:0]  fill_attr = '0;
  logic [7:0]  fill_asid = '0, fill_vmid = '0;
  logic        fill_global = 1'b0, fill_contig = 1'b0;
  logic        inv_valid = 1'b0;
  logic [2:0]  inv_op = '0;
  logic [19:0] inv_vpn = '0;
  logic [7:0]  inv_asid = '0, inv_vmid = '0;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tagged_tlb u0 (.*);

  // scoreboard queues
  bit          q_hit[$];
  logic [31:0] q_pa[$];
  logic [5:0]  q_attr[$];
  string       q_tag[$];
  event        chk_ev;

  initial begin : monitor
    forever begin
      bit e_hit; logic [31:0] e_pa; logic [5:0] e_attr; string t;
      @(chk_ev);
      #1;
      e_hit = q_hit.pop_front(); e_pa = q_pa.pop_front();
      e_attr = q_attr.pop_front(); t = q_tag.pop_front();
      tests++;
      if (lk_hit !== e_hit || walk_req !== !e_hit) begin
        fails++;
        $display("FAIL %s: hit=%b walk=%b expected hit=%b walk=%b",
                 t, lk_hit, walk_req, e_hit, !e_hit);
      end else if (e_hit && (lk_pa !== e_pa || lk_attr !== e_attr)) begin
        fails++;
        $display("FAIL %s: pa=%h attr=%h expected pa=%h attr=%h",
                 t, lk_pa, lk_attr, e_pa, e_attr);
      end
    end
  end

  task automatic push_exp(bit h, logic [31:0] pa, logic [5:0] at, string t);
    q_hit.push_back(h); q_pa.push_back(pa); q_attr.push_back(at); q_tag.push_back(t);
    -> chk_ev;
  endtask

  task automatic look(logic [31:0] va, logic [7:0] asid, logic [7:0] vmid,
                      bit h, logic [31:0] pa, logic [5:0] at, string t);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_vmid = vmid;
    push_exp(h, pa, at, t);
    #2;
    lk_valid = 1'b0;
  endtask

  task automatic set_fill(logic [19:0] vpn, logic [19:0] ppn, logic [5:0] at,
                          logic [7:0] asid, logic [7:0] vmid, bit g, bit c, bit f);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_attr = at;
    fill_asid = asid; fill_vmid = vmid; fill_global = g; fill_contig = c; fill_fault = f;
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] ppn, logic [5:0] at,
                      logic [7:0] asid, logic [7:0] vmid, bit g, bit c, bit f);
    @(negedge clk);
    set_fill(vpn, ppn, at, asid, vmid, g, c, f);
    @(negedge clk);
    fill_valid = 1'b0; fill_fault = 1'b0;
  endtask

  task automatic set_inv(logic [2:0] op, logic [19:0] vpn, logic [7:0] asid, logic [7:0] vmid);
    inv_valid = 1'b1; inv_op = op; inv_vpn = vpn; inv_asid = asid; inv_vmid = vmid;
  endtask

  task automatic inv(logic [2:0] op, logic [19:0] vpn, logic [7:0] asid, logic [7:0] vmid);
    @(negedge clk);
    set_inv(op, vpn, asid, vmid);
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    look(32'h0000_1234, 8'd1, 8'd1, 0, '0, '0, "R1 reset miss");
    // R2: basic hit
    fill(20'h00001, 20'h80001, 6'h15, 8'd1, 8'd1, 0, 0, 0);
    look(32'h0000_1234, 8'd1, 8'd1, 1, 32'h8000_1234, 6'h15, "R2 hit");
    // R3: tag mismatches
    look(32'h0000_1234, 8'd2, 8'd1, 0, '0, '0, "R3 asid mismatch");
    look(32'h0000_1234, 8'd1, 8'd2, 0, '0, '0, "R3 vmid mismatch");
    // R4: faulting fill ignored
    fill(20'h00002, 20'h80002, 6'h01, 8'd1, 8'd1, 0, 0, 1);
    look(32'h0000_2000, 8'd1, 8'd1, 0, '0, '0, "R4 fault not installed");
    // R5: global slot
    fill(20'h00003, 20'h90003, 6'h2A, 8'd1, 8'd1, 1, 0, 0);
    look(32'h0000_3ABC, 8'd9, 8'd1, 1, 32'h9000_3ABC, 6'h2A, "R5 global any asid");
    look(32'h0000_3ABC, 8'd9, 8'd2, 0, '0, '0, "R5 global vmid mismatch");
    // R6: contiguous slot
    fill(20'h00040, 20'hA0040, 6'h0F, 8'd1, 8'd1, 0, 1, 0);
    look(32'h0004_B678, 8'd1, 8'd1, 1, 32'hA004_B678, 6'h0F, "R6 contig inside");
    look(32'h0005_0000, 8'd1, 8'd1, 0, '0, '0, "R6 contig outside");
    // R12: invalidation with lookup, no-effect code
    @(negedge clk);
    set_inv(3'd5, 20'h00001, 8'd1, 8'd1);
    lk_valid = 1'b1; lk_va = 32'h0000_1234; lk_asid = 8'd1; lk_vmid = 8'd1;
    push_exp(0, '0, '0, "R12 inv forces miss");
    @(negedge clk);
    inv_valid = 1'b0; lk_valid = 1'b0;
    look(32'h0000_1234, 8'd1, 8'd1, 1, 32'h8000_1234, 6'h15, "R12 code 5 no effect");
    // R10: page+asid hits contiguous region
    inv(3'd3, 20'h00047, 8'd1, 8'd0);
    look(32'h0004_B678, 8'd1, 8'd1, 0, '0, '0, "R10 contig removed");
    look(32'h0000_1234, 8'd1, 8'd1, 1, 32'h8000_1234, 6'h15, "R10 other kept");
    // R9: asid scope spares global
    fill(20'h00005, 20'hB0005, 6'h03, 8'd2, 8'd1, 0, 0, 0);
    inv(3'd2, 20'h0, 8'd1, 8'd0);
    look(32'h0000_1234, 8'd1, 8'd1, 0, '0, '0, "R9 asid removed");
    look(32'h0000_3000, 8'd1, 8'd1, 1, 32'h9000_3000, 6'h2A, "R9 global kept");
    look(32'h0000_5010, 8'd2, 8'd1, 1, 32'hB000_5010, 6'h03, "R9 other asid kept");
    // R11: page under any asid
    inv(3'd4, 20'h00005, 8'd7, 8'd0);
    look(32'h0000_5010, 8'd2, 8'd1, 0, '0, '0, "R11 page removed");
    // R8: vmid scope
    fill(20'h00006, 20'hC0006, 6'h07, 8'd1, 8'd3, 0, 0, 0);
    inv(3'd1, 20'h0, 8'd0, 8'd3);
    look(32'h0000_6000, 8'd1, 8'd3, 0, '0, '0, "R8 vmid removed");
    look(32'h0000_3000, 8'd4, 8'd1, 1, 32'h9000_3000, 6'h2A, "R8 other vmid kept");
    // R7: all
    inv(3'd0, 20'h0, 8'd0, 8'd0);
    look(32'h0000_3000, 8'd1, 8'd1, 0, '0, '0, "R7 all removed");
    // R14: invalidate-all together with fill
    @(negedge clk);
    set_inv(3'd0, 20'h0, 8'd0, 8'd0);
    set_fill(20'h00007, 20'hD0007, 6'h11, 8'd1, 8'd1, 0, 0, 0);
    @(negedge clk);
    inv_valid = 1'b0; fill_valid = 1'b0;
    look(32'h0000_7004, 8'd1, 8'd1, 1, 32'hD000_7004, 6'h11, "R14 fill survives inv");
    // R13: replacement order
    inv(3'd0, 20'h0, 8'd0, 8'd0);
    for (int i = 0; i < 16; i++)
      fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 6'h01, 8'd1, 8'd1, 0, 0, 0);
    look(32'h0010_F000, 8'd1, 8'd1, 1, 32'h0020_F000, 6'h01, "R13 last slot filled");
    fill(20'h00300, 20'h00400, 6'h02, 8'd1, 8'd1, 0, 0, 0);
    look(32'h0010_0000, 8'd1, 8'd1, 0, '0, '0, "R13 slot0 replaced");
    look(32'h0030_0000, 8'd1, 8'd1, 1, 32'h0040_0000, 6'h02, "R13 new in slot0");
    fill(20'h00301, 20'h00401, 6'h02, 8'd1, 8'd1, 0, 0, 0);
    look(32'h0010_1000, 8'd1, 8'd1, 0, '0, '0, "R13 slot1 replaced");
    inv(3'd4, 20'h00105, 8'd0, 8'd0);
    fill(20'h00302, 20'h00402, 6'h02, 8'd1, 8'd1, 0, 0, 0);
    look(32'h0030_2000, 8'd1, 8'd1, 1, 32'h0040_2000, 6'h02, "R13 free slot used");
    look(32'h0010_2000, 8'd1, 8'd1, 1, 32'h0020_2000, 6'h01, "R13 pointer not used");
    fill(20'h00303, 20'h00403, 6'h02, 8'd1, 8'd1, 0, 0, 0);
    look(32'h0010_2000, 8'd1, 8'd1, 0, '0, '0, "R13 slot2 replaced");
    look(32'h0010_3000, 8'd1, 8'd1, 1, 32'h0020_3000, 6'h01, "R13 slot3 kept");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule